// File: doc/BRIEF.md
# Posted column command issuer with fixed four-beat bursts

This block takes read and write transactions and turns them into a stream of device commands on a single command bus: precharge, activate and column read or column write. It uses posted column timing. When a bank is closed, the activate and its column command go out in two back-to-back command slots. The device applies a programmable additive latency (AL) to the column command, so the column operation takes effect later without holding up the bus. Every column command moves exactly four data beats. Data runs at double rate, so the four beats fill two clock cycles. A burst is never cut short.

A transaction names a start address and a length of one to eight bursts. The block splits it into one column command per burst, and each column command carries its own column address. The bank index is taken from the address bits just above the beat offset, so a sequential stream rotates through the banks. An open-row table keeps one row per bank. A request to the open row goes straight to the column command. A request to another row first closes the bank with a precharge.

The device data phase is modelled as two strobes, one for read data and one for write data. Each strobe is high for the two clock cycles of a burst. Read data starts AL+CL cycles after the read command, and write data starts AL+CL−1 cycles after the write command.

Top module: `pcas_cmd_issuer`

## Requirements
- R1: After reset, cmd_code is 0 (no command), rd_stb and wr_stb are low, req_ready is high, and every bank is closed. The first access to any bank therefore begins with an activate.
- R2: The address is split as follows. Bits [1:0] are the beat offset and are ignored. Bits [3:2] give the bank, bits [9:4] the column (in burst units) and bits [17:10] the row. Consecutive burst-aligned addresses fall in successive banks, modulo 4.
- R3: A request accepted with req_len_m1 = n produces exactly n+1 column commands of the requested direction, at addresses that step by 4 from the start address. req_ready stays low from acceptance until the last of these has issued.
- R4: cmd_code encodings: 0 none, 1 activate, 2 column read, 3 column write, 4 precharge. At most one command is issued per cycle.
- R5: Only a closed bank is activated. The cycle right after an activate always carries the column command of that access, to the same bank and row.
- R6: A column command goes only to a bank whose open row equals its row. An access whose row is already open issues no activate.
- R7: An access to a bank open on another row issues a precharge to that bank, then an activate, then the column command, and no other command to that bank comes between them.
- R8: A column read issued in cycle t drives rd_stb high in cycles t+AL+CL and t+AL+CL+1, which is four beats at two beats per cycle.
- R9: A column write issued in cycle t drives wr_stb high in cycles t+AL+CL−1 and t+AL+CL.
- R10: Two column commands are at least 2 cycles apart. A column write follows a column read by at least 3 cycles. rd_stb and wr_stb are never high together.
- R11: cfg_al is in the range 0..7 and cfg_cl in the range 2..7. Both are held constant while commands or data are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_al | input | 3 | Additive latency in cycles |
| cfg_cl | input | 3 | Column latency in cycles (2..7) |
| req_valid | input | 1 | Transaction request |
| req_ready | output | 1 | Block can accept a transaction |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Start address |
| req_len_m1 | input | 3 | Number of 4-beat bursts minus one |
| cmd_code | output | 3 | Command issued this cycle |
| cmd_bank | output | 2 | Bank of the command |
| cmd_row | output | 8 | Row of the command |
| cmd_col | output | 6 | Column of the command, in bursts |
| rd_stb | output | 1 | Read data phase (two beats this cycle) |
| wr_stb | output | 1 | Write data phase (two beats this cycle) |

## Verification
The bench drives a sequential eight-burst stream. A design that took the bank from the wrong address bits would concentrate that stream in one bank, or would activate each row more than once when it comes back to a row that is already open. A directed row conflict checks for the precharge, activate, column sequence; a design that skipped the precharge would activate a bank that is still open. Read-then-write pairs at extreme AL and CL settings check the strobe offsets and the read-to-write gap. An off-by-one in latency, or a missing turnaround cycle, shows up as a strobe in the wrong cycle or as two strobes colliding. A random mix of rows and directions also checks that no activate is ever left without a column command in the next slot.

// File: rtl/pcas_pkg.sv
package pcas_pkg;

    localparam int BANKS    = 4;
    localparam int BANK_W   = $clog2(BANKS);
    localparam int OFF_W    = 2;
    localparam int COL_W    = 6;
    localparam int ROW_W    = 8;
    localparam int ADDR_W   = OFF_W + BANK_W + COL_W + ROW_W;
    localparam int LEN_W    = 3;
    localparam int AL_W     = 3;
    localparam int CL_W     = 3;
    localparam int CL_MIN   = 2;
    localparam int LAT_MAX  = (1 << AL_W) - 1 + (1 << CL_W) - 1;
    localparam int LAT_W    = $clog2(LAT_MAX + 1);
    localparam int SCHED_W  = LAT_MAX + 1;
    localparam int STEP     = 1 << OFF_W;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [BANK_W-1:0] bank;
    } dram_loc_t;

    // bank sits right above the beat offset so sequential bursts interleave
    function automatic dram_loc_t map_addr(input logic [ADDR_W-1:0] a);
        dram_loc_t l;
        l.bank = a[OFF_W +: BANK_W];
        l.col  = a[OFF_W+BANK_W +: COL_W];
        l.row  = a[OFF_W+BANK_W+COL_W +: ROW_W];
        return l;
    endfunction

endpackage

// File: rtl/pcas_burst_split.sv
module pcas_burst_split
    import pcas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_m1,
    output logic              sub_valid,
    output logic              sub_write,
    output dram_loc_t         sub_loc,
    output logic              sub_last,
    input  logic              sub_take
);

    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(STEP - 1);

    logic              act_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;

    assign req_ready = !act_q;
    assign sub_valid = act_q;
    assign sub_write = wr_q;
    assign sub_loc   = map_addr(addr_q);
    assign sub_last  = (rem_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            rem_q  <= '0;
        end else if (req_valid && req_ready) begin
            act_q  <= 1'b1;
            wr_q   <= req_write;
            addr_q <= req_addr & ~OFF_MASK;
            rem_q  <= req_len_m1;
        end else if (sub_take) begin
            if (sub_last) begin
                act_q <= 1'b0;
            end else begin
                addr_q <= addr_q + ADDR_W'(STEP);
                rem_q  <= rem_q - 1'b1;
            end
        end
    end

    // R2: the next burst of a split transfer lands in the next bank
    p_bank_step_r2: assert property (@(posedge clk) disable iff (rst)
        (sub_take && !sub_last) |=>
            (sub_valid && sub_loc.bank == BANK_W'($past(sub_loc.bank) + 1'b1)));

    // R3: a split transfer keeps its direction and is not replaced mid-way
    p_dir_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (sub_take && !sub_last) |=> (sub_write == $past(sub_write) && !req_ready));

endmodule

// File: rtl/pcas_bank_table.sv
module pcas_bank_table
    import pcas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              act_en,
    input  logic              pre_en,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    output logic              q_open,
    output logic              q_match
);

    logic [BANKS-1:0] open_v;
    logic [ROW_W-1:0] row_v [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic             open_q;
        logic [ROW_W-1:0] row_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q <= 1'b0;
                row_q  <= '0;
            end else if (act_en && upd_bank == BANK_W'(b)) begin
                open_q <= 1'b1;
                row_q  <= upd_row;
            end else if (pre_en && upd_bank == BANK_W'(b)) begin
                open_q <= 1'b0;
            end
        end
        assign open_v[b] = open_q;
        assign row_v[b]  = row_q;
    end

    assign q_open  = open_v[upd_bank];
    assign q_match = q_open && (row_v[upd_bank] == upd_row);

    // R5: activates go only to closed banks
    p_act_closed_r5: assert property (@(posedge clk) disable iff (rst)
        act_en |-> !open_v[upd_bank]);

    // R7: precharges go only to open banks holding a different row
    p_pre_open_r7: assert property (@(posedge clk) disable iff (rst)
        pre_en |-> (open_v[upd_bank] && row_v[upd_bank] != upd_row));

endmodule

// File: rtl/pcas_data_sched.sv
module pcas_data_sched
    import pcas_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AL_W-1:0] cfg_al,
    input  logic [CL_W-1:0] cfg_cl,
    input  logic            col_fire,
    input  logic            col_write,
    output logic            rd_stb,
    output logic            wr_stb
);

    localparam logic [SCHED_W-1:0] PAIR = SCHED_W'(3);

    logic [LAT_W-1:0]   lat;
    logic [SCHED_W-1:0] rd_q, wr_q, rd_set, wr_set;

    assign lat    = LAT_W'(cfg_al) + LAT_W'(cfg_cl);
    assign rd_set = (col_fire && !col_write) ? (PAIR << (lat - LAT_W'(1))) : '0;
    assign wr_set = (col_fire &&  col_write) ? (PAIR << (lat - LAT_W'(2))) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
            wr_q <= '0;
        end else begin
            rd_q <= (rd_q >> 1) | rd_set;
            wr_q <= (wr_q >> 1) | wr_set;
        end
    end

    assign rd_stb = rd_q[0];
    assign wr_stb = wr_q[0];

    // R10: read and write data phases never overlap
    p_bus_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb));

    // R8: a read data phase lasts at least two cycles
    p_rd_pair_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_stb) |=> rd_stb);

    // R9: a write data phase lasts at least two cycles
    p_wr_pair_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_stb) |=> wr_stb);

    // R11: column latency never below its minimum
    p_cl_min_r11: assert property (@(posedge clk) disable iff (rst)
        cfg_cl >= CL_W'(CL_MIN));

endmodule

// File: rtl/pcas_cmd_issuer.sv
module pcas_cmd_issuer
    import pcas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [AL_W-1:0]   cfg_al,
    input  logic [CL_W-1:0]   cfg_cl,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_m1,
    output logic [2:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              rd_stb,
    output logic              wr_stb
);

    logic      sub_valid, sub_write, sub_last, sub_take;
    dram_loc_t sub_loc;
    logic      q_open, q_match, act_en, pre_en;
    cmd_e      cmd;
    logic [1:0] since_col_q;
    logic       last_rd_q;
    logic [2:0] need_gap, since_ext;
    logic       col_ok, act_ok;

    pcas_burst_split u_split (
        .clk, .rst, .req_valid, .req_ready, .req_write, .req_addr, .req_len_m1,
        .sub_valid, .sub_write, .sub_loc, .sub_last, .sub_take
    );

    pcas_bank_table u_banks (
        .clk, .rst, .act_en, .pre_en,
        .upd_bank(sub_loc.bank), .upd_row(sub_loc.row),
        .q_open, .q_match
    );

    pcas_data_sched u_data (
        .clk, .rst, .cfg_al, .cfg_cl,
        .col_fire(sub_take), .col_write(sub_write),
        .rd_stb, .wr_stb
    );

    // column spacing: 2 slots per burst, one extra for read-to-write turnaround
    assign need_gap  = (sub_write && last_rd_q) ? 3'd3 : 3'd2;
    assign since_ext = {1'b0, since_col_q};
    assign col_ok    = since_ext >= need_gap;
    assign act_ok    = (since_ext + 3'd1) >= need_gap;

    always_comb begin
        cmd      = CMD_NOP;
        act_en   = 1'b0;
        pre_en   = 1'b0;
        sub_take = 1'b0;
        if (sub_valid) begin
            if (!q_open) begin
                if (act_ok) begin
                    cmd    = CMD_ACT;
                    act_en = 1'b1;
                end
            end else if (!q_match) begin
                cmd    = CMD_PRE;
                pre_en = 1'b1;
            end else if (col_ok) begin
                cmd      = sub_write ? CMD_WR : CMD_RD;
                sub_take = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            since_col_q <= 2'd3;
            last_rd_q   <= 1'b0;
        end else if (sub_take) begin
            since_col_q <= 2'd1;
            last_rd_q   <= !sub_write;
        end else if (since_col_q != 2'd3) begin
            since_col_q <= since_col_q + 2'd1;
        end
    end

    assign cmd_code = cmd;
    assign cmd_bank = (cmd != CMD_NOP) ? sub_loc.bank : '0;
    assign cmd_row  = (cmd != CMD_NOP) ? sub_loc.row  : '0;
    assign cmd_col  = (cmd == CMD_RD || cmd == CMD_WR) ? sub_loc.col : '0;

    // R5: posted column command follows its activate in the very next slot
    p_posted_col_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT) |=>
            ((cmd == CMD_RD || cmd == CMD_WR) &&
             cmd_bank == $past(cmd_bank) && cmd_row == $past(cmd_row)));

    // R7: after a precharge the same access can only activate or wait
    p_pre_then_act_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |=> (cmd == CMD_ACT || cmd == CMD_NOP));

    // R10: no two column commands in adjacent cycles
    p_col_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_WR) |=> !(cmd == CMD_RD || cmd == CMD_WR));

    // R10: write column at least three cycles after a read column
    p_wr_after_rd_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WR) |-> ($past(cmd) != CMD_RD && $past(cmd, 2) != CMD_RD));

    // R6: column commands only to an open matching row
    p_col_open_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_WR) |-> q_match);

endmodule

// File: tb/sim_pcas_cmd_issuer.sv
`timescale 1ns/1ps
module sim_pcas_cmd_issuer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_al = 3'd0;
    logic [2:0]  cfg_cl = 3'd3;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [2:0]  req_len_m1 = '0;
    logic [2:0]  cmd_code;
    logic [1:0]  cmd_bank;
    logic [7:0]  cmd_row;
    logic [5:0]  cmd_col;
    logic        rd_stb, wr_stb;

    always #2.5 clk = ~clk;

    pcas_cmd_issuer u0 (.*);

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    bit mon_en = 1'b0, done = 1'b0;

    int exp_bank[0:4095], exp_row[0:4095], exp_col[0:4095];
    bit exp_wr[0:4095];
    int head = 0, tail = 0;
    bit exp_rd_s[0:255], exp_wr_s[0:255];
    bit m_open[4];
    int m_row[4];
    int last_col_cyc = -100;
    bit last_col_rd = 1'b0;
    int prev_code = 0, prev_bank = 0, prev_row = 0;
    int n_act = 0;
    int bank_hist[4];
    int log_code[0:7];
    int log_n = 0;

    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: checks every command and strobe against the bench model
    always @(negedge clk) begin
        if (mon_en && !done) begin
            int code, b, r, lat;
            code = int'(cmd_code);
            b = int'(cmd_bank);
            r = int'(cmd_row);
            lat = int'(cfg_al) + int'(cfg_cl);
            if (code > 4) chk(0, "R4", "code range", code, 4);
            if (rd_stb != exp_rd_s[cyc % 256])
                chk(0, "R8", "rd_stb", int'(rd_stb), int'(exp_rd_s[cyc % 256]));
            if (wr_stb != exp_wr_s[cyc % 256])
                chk(0, "R9", "wr_stb", int'(wr_stb), int'(exp_wr_s[cyc % 256]));
            if (exp_rd_s[cyc % 256] || exp_wr_s[cyc % 256]) n_tests++;
            exp_rd_s[cyc % 256] = 1'b0;
            exp_wr_s[cyc % 256] = 1'b0;
            if (prev_code == 1)
                chk((code == 2 || code == 3) && b == prev_bank && r == prev_row,
                    "R5", "column after activate", code, 2);
            if (code != 0 && log_n < 8) begin
                log_code[log_n] = code;
                log_n++;
            end
            case (code)
                1: begin
                    chk(!m_open[b], "R5", "activate to open bank", b, -1);
                    chk(head < tail && b == exp_bank[head] && r == exp_row[head],
                        "R2", "activate target row", r, exp_row[head]);
                    m_open[b] = 1'b1;
                    m_row[b] = r;
                    n_act++;
                end
                4: begin
                    chk(m_open[b] && head < tail && b == exp_bank[head] &&
                        m_row[b] != exp_row[head], "R7", "precharge need", b, exp_bank[head]);
                    m_open[b] = 1'b0;
                end
                2, 3: begin
                    int gap;
                    chk(head < tail, "R3", "unexpected column", code, 0);
                    chk(b == exp_bank[head] && r == exp_row[head] &&
                        int'(cmd_col) == exp_col[head] && (code == 3) == exp_wr[head],
                        "R3", "column target", int'(cmd_col), exp_col[head]);
                    chk(m_open[b] && m_row[b] == r, "R6", "column to closed row", r, m_row[b]);
                    gap = cyc - last_col_cyc;
                    chk(gap >= 2 && !(code == 3 && last_col_rd && gap < 3),
                        "R10", "column gap", gap, 3);
                    if (code == 2) begin
                        exp_rd_s[(cyc + lat) % 256] = 1'b1;
                        exp_rd_s[(cyc + lat + 1) % 256] = 1'b1;
                    end else begin
                        exp_wr_s[(cyc + lat - 1) % 256] = 1'b1;
                        exp_wr_s[(cyc + lat) % 256] = 1'b1;
                    end
                    bank_hist[b]++;
                    last_col_cyc = cyc;
                    last_col_rd = (code == 2);
                    head++;
                end
                default: ;
            endcase
            prev_code = code;
            prev_bank = b;
            prev_row = r;
        end
    end

    task automatic send(input int addr, input bit wr, input int len_m1);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr = 18'(addr);
        req_len_m1 = 3'(len_m1);
        for (int k = 0; k <= len_m1; k++) begin
            int a;
            a = ((addr & ~3) + 4 * k) & 18'h3ffff;
            exp_bank[tail] = (a >> 2) & 3;
            exp_col[tail] = (a >> 4) & 63;
            exp_row[tail] = (a >> 10) & 255;
            exp_wr[tail] = wr;
            tail++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R3", "ready low after accept", int'(req_ready), 0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(req_ready && head == tail)) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        int unsigned seed;
        int a0, blog;
        seed = $urandom(32'd4021);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_code == 3'd0 && !rd_stb && !wr_stb && req_ready,
            "R1", "reset outputs", int'(cmd_code), 0);
        @(posedge clk);
        mon_en = 1'b1;

        // sequential stream: 8 bursts spread over 4 banks, second pass hits open rows
        for (int i = 0; i < 4; i++) bank_hist[i] = 0;
        a0 = n_act;
        log_n = 0;
        send(1, 1'b0, 7);
        wait_idle();
        chk(log_code[0] == 1, "R1", "first command activates", log_code[0], 1);
        for (int i = 0; i < 4; i++)
            chk(bank_hist[i] == 2, "R2", "bursts per bank", bank_hist[i], 2);
        chk(n_act - a0 == 4, "R6", "activates in row-hit stream", n_act - a0, 4);

        // row conflict in bank 0: precharge, activate, read
        log_n = 0;
        send(1 << 10, 1'b0, 0);
        wait_idle();
        chk(log_n == 3 && log_code[0] == 4 && log_code[1] == 1 && log_code[2] == 2,
            "R7", "conflict sequence", log_code[0], 4);

        // read then write to an open row with long latency
        cfg_al = 3'd7;
        cfg_cl = 3'd7;
        send(4, 1'b0, 0);
        send(4 + 16, 1'b1, 1);
        wait_idle();
        chk(head == tail, "R9", "long latency drained", head, tail);

        // shortest latency, alternating directions
        cfg_al = 3'd0;
        cfg_cl = 3'd2;
        send(8, 1'b1, 0);
        send(12, 1'b0, 0);
        send(8 + 32, 1'b1, 2);
        wait_idle();

        // random phases
        for (int ph = 0; ph < 4; ph++) begin
            cfg_al = 3'($urandom % 8);
            cfg_cl = 3'(2 + $urandom % 6);
            for (int n = 0; n < 60; n++) begin
                int ad;
                ad = (($urandom % 2) << 10) | (($urandom % 64) << 4) |
                     (($urandom % 4) << 2) | ($urandom % 4);
                send(ad, 1'($urandom % 2), $urandom % 4);
            end
            wait_idle();
        end

        blog = tail - head;
        chk(blog == 0, "R3", "columns outstanding", blog, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule